// File: doc/BRIEF.md
# Cartridge Bank and Mirroring Controller

This block sits between a console CPU, its picture processor and the ROM/RAM arrays of a game cartridge. It watches CPU writes in the upper half of the address map, decodes a small set of them into a CHR bank register, a bank register for the 0x6000–0x7FFF window and a nametable mirroring bit. From those registers it forms the expanded PRG ROM address for CPU reads in 0x6000–0xFFFF, the expanded CHR address for pattern fetches, a write enable for CHR RAM on boards that carry RAM in place of CHR ROM, and the nametable address-line select.

Both PRG and CHR banks are 8 KB. The 0x6000 window is switchable. The four 8 KB slots in 0x8000–0xFFFF are always tied to the last four ROM banks, computed from a bank-count input. One CHR bank covers the full 0x0000–0x1FFF pattern space. Every output is registered, so each result appears one clock after the inputs that produce it. A register write lands on the clock edge at which the write strobe is high, and the next read already uses the new value.

Top module: `cart_mapper`

## Requirements
- R1: With reset high, the window bank and the CHR bank registers clear to 0, `mirror_horiz` takes the value of `dflt_mirror_h`, and `prg_en`, `chr_ram_we` and the address outputs are 0.
- R2: A write (`cpu_wr` high) whose address ANDed with 0xE003 equals 0x8000 loads the CHR bank from `cpu_data[3:0]`. Bits 7:4 are dropped.
- R3: A write whose masked address equals 0xE000 loads the window bank from `cpu_data[3:0]`. Bits 7:4 are dropped.
- R4: A write whose masked address equals 0xE001 sets `mirror_horiz` to `cpu_data[3]` (1 = horizontal, 0 = vertical). It is visible on `mirror_horiz` one clock after the write edge.
- R5: Any other write, including masked value 0xE002, and any cycle with `cpu_wr` low, leaves all three registers unchanged.
- R6: For a CPU address in 0x6000–0x7FFF, `prg_addr` becomes {window bank zero-extended, `cpu_addr[12:0]`} one clock later. A write in cycle k is seen by a read in cycle k+1.
- R7: For a CPU address in 0x8000–0xFFFF, `prg_addr` becomes {`bank_count` − 4 + `cpu_addr[14:13]`, `cpu_addr[12:0]`} one clock later, computed modulo 2^PRG_BANK_W.
- R8: `prg_en` is `cpu_rd` AND (address ≥ 0x6000), registered. `prg_addr` is 0 one clock after an address below 0x6000.
- R9: `chr_en` is registered (`ppu_addr[13]` == 0). When it is set, `chr_addr` is {CHR bank, `ppu_addr[12:0]`}; otherwise `chr_addr` is 0.
- R10: `chr_ram_we` is registered `chr_is_ram` AND `ppu_wr` AND (`ppu_addr[13]` == 0).
- R11: `nt_a10` is registered `ppu_addr[11]` when the mirroring bit is horizontal and `ppu_addr[10]` when it is vertical. It uses the mirroring value from before a same-edge write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| ppu_addr | input | 14 | Picture processor address |
| ppu_wr | input | 1 | Picture processor write strobe |
| dflt_mirror_h | input | 1 | Mirroring loaded at reset, 1 = horizontal |
| chr_is_ram | input | 1 | Board has CHR RAM instead of CHR ROM |
| bank_count | input | PRG_BANK_W | Number of 8 KB PRG banks in the ROM |
| prg_addr | output | PRG_BANK_W+13 | Expanded PRG ROM address |
| prg_en | output | 1 | PRG ROM read select |
| chr_addr | output | SEL_W+13 | Expanded CHR address |
| chr_en | output | 1 | Pattern-space select |
| chr_ram_we | output | 1 | CHR RAM write enable |
| nt_a10 | output | 1 | Nametable address line 10 select |
| mirror_horiz | output | 1 | Current mirroring bit |

## Verification
Every address and enable output is due exactly one clock after the inputs that form it, and it uses the register contents from before any write at that same edge. `mirror_horiz` shows a write one clock after the write edge. The bench drives on the falling edge and samples on the next falling edge. It computes the expected addresses from the bench model before it applies that cycle's write to the model, and it compares `mirror_horiz` only after applying the write. This lets write-then-read sequences, and writes that collide with a read, be checked at the right cycle.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

  localparam int PAGE_W = 13;

  typedef enum logic [1:0] {
    WR_NONE,
    WR_CHR,
    WR_WIN,
    WR_MIR
  } wr_kind_e;

  function automatic wr_kind_e decode_write(input logic [15:0] a);
    logic [15:0] m;
    m = a & 16'hE003;
    case (m)
      16'h8000: return WR_CHR;
      16'hE000: return WR_WIN;
      16'hE001: return WR_MIR;
      default:  return WR_NONE;
    endcase
  endfunction

endpackage

// File: rtl/mapper_regs.sv
module mapper_regs
  import mapper_pkg::*;
#(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [15:0]      cpu_addr,
  input  logic [7:0]       cpu_data,
  input  logic             cpu_wr,
  input  logic             dflt_mirror_h,
  output logic [SEL_W-1:0] win_bank,
  output logic [SEL_W-1:0] chr_bank,
  output logic             mirror_h
);

  wr_kind_e kind;

  always_comb begin
    kind = cpu_wr ? decode_write(cpu_addr) : WR_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_bank <= '0;
      chr_bank <= '0;
      mirror_h <= dflt_mirror_h;
    end else begin
      case (kind)
        WR_CHR:  chr_bank <= cpu_data[SEL_W-1:0];
        WR_WIN:  win_bank <= cpu_data[SEL_W-1:0];
        WR_MIR:  mirror_h <= cpu_data[3];
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/mapper_prg_map.sv
module mapper_prg_map
  import mapper_pkg::*;
#(
  parameter int BANK_W = 8,
  parameter int SEL_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [15:0]              cpu_addr,
  input  logic                     cpu_rd,
  input  logic [BANK_W-1:0]        bank_count,
  input  logic [SEL_W-1:0]         win_bank,
  output logic [BANK_W+PAGE_W-1:0] prg_addr,
  output logic                     prg_en
);

  localparam int SLOTS = 4;
  localparam int OUT_W = BANK_W + PAGE_W;

  logic [BANK_W-1:0] fixed_bank [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign fixed_bank[s] = bank_count - BANK_W'(SLOTS) + BANK_W'(s);
  end

  logic              in_win;
  logic              in_hi;
  logic [BANK_W-1:0] bank_c;
  logic [OUT_W-1:0]  addr_c;

  always_comb begin
    in_win = (cpu_addr[15:13] == 3'b011);
    in_hi  = cpu_addr[15];
    bank_c = in_win ? BANK_W'(win_bank) : fixed_bank[cpu_addr[14:13]];
    addr_c = (in_win || in_hi) ? {bank_c, cpu_addr[PAGE_W-1:0]} : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prg_addr <= '0;
      prg_en   <= 1'b0;
    end else begin
      prg_addr <= addr_c;
      prg_en   <= cpu_rd && (in_win || in_hi);
    end
  end

endmodule

// File: rtl/mapper_chr_map.sv
module mapper_chr_map
  import mapper_pkg::*;
#(
  parameter int SEL_W = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [13:0]             ppu_addr,
  input  logic                    ppu_wr,
  input  logic                    chr_is_ram,
  input  logic [SEL_W-1:0]        chr_bank,
  input  logic                    mirror_h,
  output logic [SEL_W+PAGE_W-1:0] chr_addr,
  output logic                    chr_en,
  output logic                    chr_ram_we,
  output logic                    nt_a10
);

  logic pat;

  always_comb begin
    pat = ~ppu_addr[13];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chr_addr   <= '0;
      chr_en     <= 1'b0;
      chr_ram_we <= 1'b0;
      nt_a10     <= 1'b0;
    end else begin
      chr_addr   <= pat ? {chr_bank, ppu_addr[PAGE_W-1:0]} : '0;
      chr_en     <= pat;
      chr_ram_we <= pat && ppu_wr && chr_is_ram;
      nt_a10     <= mirror_h ? ppu_addr[11] : ppu_addr[10];
    end
  end

endmodule

// File: rtl/cart_mapper.sv
module cart_mapper
  import mapper_pkg::*;
#(
  parameter int PRG_BANK_W = 8,
  parameter int SEL_W      = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [15:0]                  cpu_addr,
  input  logic [7:0]                   cpu_data,
  input  logic                         cpu_wr,
  input  logic                         cpu_rd,
  input  logic [13:0]                  ppu_addr,
  input  logic                         ppu_wr,
  input  logic                         dflt_mirror_h,
  input  logic                         chr_is_ram,
  input  logic [PRG_BANK_W-1:0]        bank_count,
  output logic [PRG_BANK_W+PAGE_W-1:0] prg_addr,
  output logic                         prg_en,
  output logic [SEL_W+PAGE_W-1:0]      chr_addr,
  output logic                         chr_en,
  output logic                         chr_ram_we,
  output logic                         nt_a10,
  output logic                         mirror_horiz
);

  logic [SEL_W-1:0] win_bank;
  logic [SEL_W-1:0] chr_bank;
  logic             mirror_h;

  mapper_regs #(.SEL_W(SEL_W)) u_regs (
    .clk           (clk),
    .rst           (rst),
    .cpu_addr      (cpu_addr),
    .cpu_data      (cpu_data),
    .cpu_wr        (cpu_wr),
    .dflt_mirror_h (dflt_mirror_h),
    .win_bank      (win_bank),
    .chr_bank      (chr_bank),
    .mirror_h      (mirror_h)
  );

  mapper_prg_map #(.BANK_W(PRG_BANK_W), .SEL_W(SEL_W)) u_prg (
    .clk        (clk),
    .rst        (rst),
    .cpu_addr   (cpu_addr),
    .cpu_rd     (cpu_rd),
    .bank_count (bank_count),
    .win_bank   (win_bank),
    .prg_addr   (prg_addr),
    .prg_en     (prg_en)
  );

  mapper_chr_map #(.SEL_W(SEL_W)) u_chr (
    .clk        (clk),
    .rst        (rst),
    .ppu_addr   (ppu_addr),
    .ppu_wr     (ppu_wr),
    .chr_is_ram (chr_is_ram),
    .chr_bank   (chr_bank),
    .mirror_h   (mirror_h),
    .chr_addr   (chr_addr),
    .chr_en     (chr_en),
    .chr_ram_we (chr_ram_we),
    .nt_a10     (nt_a10)
  );

  assign mirror_horiz = mirror_h;

endmodule

// File: rtl/cart_mapper_checker.sv
module cart_mapper_checker #(
  parameter int BANK_W = 8,
  parameter int SEL_W  = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [15:0]        cpu_addr,
  input logic               cpu_wr,
  input logic               cpu_rd,
  input logic               chr_is_ram,
  input logic [BANK_W-1:0]  bank_count,
  input logic [SEL_W-1:0]   win_bank,
  input logic [SEL_W-1:0]   chr_bank,
  input logic               mirror_h,
  input logic [BANK_W+12:0] prg_addr,
  input logic               prg_en,
  input logic               chr_ram_we
);

  AST_WIN_OFFSET: assert property (@(posedge clk) disable iff (rst)
    (cpu_addr[15:13] == 3'b011) |=>
      (prg_addr[12:0] == $past(cpu_addr[12:0]) &&
       prg_addr[BANK_W+12:13] == BANK_W'($past(win_bank)))); // R6

  AST_LAST_SLOT: assert property (@(posedge clk) disable iff (rst)
    (cpu_addr[15:13] == 3'b111) |=>
      (prg_addr[BANK_W+12:13] == BANK_W'($past(bank_count) - BANK_W'(1)))); // R7

  AST_PRG_QUIET: assert property (@(posedge clk) disable iff (rst)
    !cpu_rd |=> !prg_en); // R8

  AST_HOLD_NO_WR: assert property (@(posedge clk) disable iff (rst)
    !cpu_wr |=> ($stable(win_bank) && $stable(chr_bank) && $stable(mirror_h))); // R5

  AST_CHR_ROM_NO_WE: assert property (@(posedge clk) disable iff (rst)
    !chr_is_ram |=> !chr_ram_we); // R10

endmodule

bind cart_mapper cart_mapper_checker #(.BANK_W(PRG_BANK_W), .SEL_W(SEL_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cpu_addr   (cpu_addr),
  .cpu_wr     (cpu_wr),
  .cpu_rd     (cpu_rd),
  .chr_is_ram (chr_is_ram),
  .bank_count (bank_count),
  .win_bank   (win_bank),
  .chr_bank   (chr_bank),
  .mirror_h   (mirror_h),
  .prg_addr   (prg_addr),
  .prg_en     (prg_en),
  .chr_ram_we (chr_ram_we)
);

// File: tb/tb_cart_mapper.sv
module tb_cart_mapper;

  localparam int CLK_PERIOD = 10;
  localparam int BW = 8;
  localparam int SW = 4;
  localparam int PW = BW + 13;
  localparam int CW = SW + 13;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [15:0]   cpu_addr = '0;
  logic [7:0]    cpu_data = '0;
  logic          cpu_wr = 1'b0;
  logic          cpu_rd = 1'b0;
  logic [13:0]   ppu_addr = '0;
  logic          ppu_wr = 1'b0;
  logic          dflt_mirror_h = 1'b0;
  logic          chr_is_ram = 1'b0;
  logic [BW-1:0] bank_count = 8'd11;
  logic [PW-1:0] prg_addr;
  logic          prg_en;
  logic [CW-1:0] chr_addr;
  logic          chr_en;
  logic          chr_ram_we;
  logic          nt_a10;
  logic          mirror_horiz;

  int n_checks = 0;
  int n_fails  = 0;

  logic [SW-1:0] m_win;
  logic [SW-1:0] m_chr;
  logic          m_mir;

  cart_mapper #(.PRG_BANK_W(BW), .SEL_W(SW)) dut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .ppu_addr(ppu_addr), .ppu_wr(ppu_wr),
    .dflt_mirror_h(dflt_mirror_h), .chr_is_ram(chr_is_ram),
    .bank_count(bank_count), .prg_addr(prg_addr), .prg_en(prg_en),
    .chr_addr(chr_addr), .chr_en(chr_en), .chr_ram_we(chr_ram_we),
    .nt_a10(nt_a10), .mirror_horiz(mirror_horiz)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] exp_prg(input logic [15:0] a, input logic [SW-1:0] w,
                                            input logic [BW-1:0] bc);
    logic [BW-1:0] b;
    if (a[15:13] == 3'b011) return {BW'(w), a[12:0]};
    if (a[15]) begin
      b = bc - BW'(4) + BW'(a[14:13]);
      return {b, a[12:0]};
    end
    return '0;
  endfunction

  // Drive at a falling edge, sample at the next falling edge.
  task automatic cyc(input logic [15:0] a, input logic [7:0] d, input logic wr,
                     input logic rd, input logic [13:0] pa, input logic pwr);
    logic pat;
    cpu_addr = a; cpu_data = d; cpu_wr = wr; cpu_rd = rd;
    ppu_addr = pa; ppu_wr = pwr;
    @(negedge clk);
    pat = ~pa[13];
    chk("R6/R7 prg_addr", 32'(prg_addr), 32'(exp_prg(a, m_win, bank_count)));
    chk("R8 prg_en", 32'(prg_en), 32'(rd && (a >= 16'h6000)));
    chk("R9 chr_en", 32'(chr_en), 32'(pat));
    chk("R9 chr_addr", 32'(chr_addr), pat ? 32'({m_chr, pa[12:0]}) : 32'd0);
    chk("R10 chr_ram_we", 32'(chr_ram_we), 32'(pat && pwr && chr_is_ram));
    chk("R11 nt_a10", 32'(nt_a10), 32'(m_mir ? pa[11] : pa[10]));
    if (wr) begin
      case (a & 16'hE003)
        16'h8000: m_chr = d[3:0];     // R2
        16'hE000: m_win = d[3:0];     // R3
        16'hE001: m_mir = d[3];       // R4
        default: ;                    // R5
      endcase
    end
    chk("R4/R5 mirror_horiz", 32'(mirror_horiz), 32'(m_mir));
  endtask

  task automatic do_reset(input logic dm);
    dflt_mirror_h = dm;
    rst = 1'b1;
    cpu_wr = 1'b0; cpu_rd = 1'b0; ppu_wr = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 prg_en", 32'(prg_en), 32'd0);
    chk("R1 prg_addr", 32'(prg_addr), 32'd0);
    chk("R1 chr_ram_we", 32'(chr_ram_we), 32'd0);
    chk("R1 mirror_horiz", 32'(mirror_horiz), 32'(dm));
    rst = 1'b0;
    m_win = '0; m_chr = '0; m_mir = dm;
    // R1: banks read back as 0
    cyc(16'h6123, 8'h00, 1'b0, 1'b1, 14'h0456, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    @(negedge clk);
    do_reset(1'b1);
    do_reset(1'b0);

    // Directed corners
    cyc(16'hE000, 8'hF3, 1'b1, 1'b0, 14'h0000, 1'b0);   // R3 upper bits dropped
    cyc(16'h7FFF, 8'h00, 1'b0, 1'b1, 14'h1FFF, 1'b0);   // R6 next-cycle read sees bank 3
    cyc(16'h8000, 8'hF5, 1'b1, 1'b1, 14'h0100, 1'b0);   // R2 write during read
    cyc(16'h0010, 8'h00, 1'b0, 1'b1, 14'h0100, 1'b0);   // R2 new CHR bank, R8 low address
    cyc(16'hE001, 8'h08, 1'b1, 1'b0, 14'h2C00, 1'b0);   // R4 horizontal
    cyc(16'hE001, 8'hF7, 1'b1, 1'b0, 14'h2800, 1'b0);   // R4 vertical, R11 old value
    cyc(16'hE002, 8'hFF, 1'b1, 1'b0, 14'h2400, 1'b0);   // R5 ignored
    cyc(16'h8001, 8'h0A, 1'b1, 1'b0, 14'h0000, 1'b0);   // R5 ignored
    cyc(16'hA000, 8'h0A, 1'b1, 1'b0, 14'h0000, 1'b0);   // R5 ignored
    cyc(16'h6000, 8'h0A, 1'b1, 1'b1, 14'h0000, 1'b0);   // R5 ignored
    cyc(16'hFFFC, 8'h09, 1'b1, 1'b1, 14'h0000, 1'b0);   // R3 via mask alias
    cyc(16'h9FFC, 8'h0C, 1'b1, 1'b1, 14'h0000, 1'b0);   // R2 via mask alias
    cyc(16'hE000, 8'h06, 1'b0, 1'b1, 14'h0000, 1'b0);   // R5 strobe low
    cyc(16'h8000, 8'h00, 1'b0, 1'b1, 14'h0000, 1'b0);   // R7 first fixed slot
    cyc(16'hA000, 8'h00, 1'b0, 1'b1, 14'h0000, 1'b0);   // R7
    cyc(16'hC000, 8'h00, 1'b0, 1'b1, 14'h0000, 1'b0);   // R7
    cyc(16'hFFFF, 8'h00, 1'b0, 1'b1, 14'h0000, 1'b0);   // R7 last slot
    chr_is_ram = 1'b1;
    cyc(16'h0000, 8'h00, 1'b0, 1'b0, 14'h0ABC, 1'b1);   // R10 RAM write
    cyc(16'h0000, 8'h00, 1'b0, 1'b0, 14'h2ABC, 1'b1);   // R10 outside pattern space
    chr_is_ram = 1'b0;
    cyc(16'h0000, 8'h00, 1'b0, 1'b0, 14'h0ABC, 1'b1);   // R10 ROM board

    // Constrained random
    for (int ph = 0; ph < 4; ph++) begin
      bank_count = BW'($urandom_range(4, 255));
      chr_is_ram = ph[0];
      for (int i = 0; i < 1500; i++) begin
        logic [15:0] a;
        logic [1:0]  sel;
        a = 16'($urandom);
        sel = 2'($urandom);
        if (sel == 2'd0) a[15:13] = 3'b111;
        if (sel == 2'd1) a[15:13] = 3'b100;
        if (sel == 2'd2) a[15:13] = 3'b011;
        if ($urandom_range(0, 1) == 0) a[1:0] = 2'($urandom_range(0, 2));
        cyc(a, 8'($urandom), 1'($urandom), 1'($urandom), 14'($urandom), 1'($urandom));
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule